// File: doc/BRIEF.md
# Banked Asynchronous SRAM Bus Front End

This block sits behind a byte-wide asynchronous SRAM-style bus and serves it from four equal internal memory banks. The bus carries active-low chip, write and output enables, an address, and a data path split into an input byte, an output byte and an output-enable flag. All strobes are sampled on a fast core clock. The two most significant address bits choose the bank and the remaining bits index within it.

A write lasts while chip-enable and write-enable are both low. The window opens at whichever of the two falls later and closes at whichever rises first. The byte is captured on every clock while the window is open, and the last captured value is stored when the window closes. The address is taken when the window opens; if it moves before the window closes, the write is dropped and a sticky error flag is set.

A protect input from a power supervisor makes every strobe look inactive. While it is high, nothing is stored and the output driver stays off. Read data is registered, so a new address shows on the output one clock later.

Top module: `sram_fe`

## Requirements
- R1: Address bits [ADDR_W-1:ADDR_W-2] pick one of four banks and the lower bits index within that bank. At most one bank is written per clock. Equal low indices in different banks hold independent bytes.
- R2: While ce_ni is high, data_oe_o is 0 and no byte is stored, whatever we_ni and oe_ni are.
- R3: With ce_ni low, we_ni high and oe_ni high, data_oe_o is 0 and no byte is stored.
- R4: With ce_ni low, we_ni high and oe_ni low, data_oe_o is 1. data_o shows the byte at addr_i one clock after the address is applied, and it keeps the old byte until that clock.
- R5: The write window opens on the first clock where ce_ni and we_ni are both low, and it closes on the first clock where either one is high. The byte stored is the data_i value sampled on the last clock before the close. The data_i value present at the closing clock is not used.
- R6: When we_ni goes low while the output is driven, data_oe_o drops to 0 in the same cycle, whatever oe_ni is.
- R7: If ce_ni goes low in the same clock as we_ni or later, data_oe_o stays 0 until ce_ni goes high again. This holds even after we_ni rises with oe_ni low. If ce_ni goes low first, the output is driven again once we_ni rises.
- R8: If addr_i differs from the window's opening address on any clock inside the window, nothing is stored at either address. err_o then goes to 1 and stays at 1 until reset.
- R9: While protect_i is 1, all strobes count as inactive. data_oe_o is 0 and nothing is stored. If protect_i rises during an open window, that write is cancelled.
- R10: After reset, data_oe_o and err_o are 0 and every memory byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| protect_i | input | 1 | Supervisor write/output inhibit, active high |
| addr_i | input | ADDR_W | Byte address; top two bits select the bank |
| data_i | input | DATA_W | Write data from the bus |
| data_o | output | DATA_W | Registered read data |
| data_oe_o | output | 1 | Output driver enable for data_o |
| err_o | output | 1 | Sticky flag for an address change inside a write window |

## Verification
Some rules are checked by assertions on every cycle:
- a deselected chip or a low write-enable never drives the output;
- protect blocks every bank write;
- no more than one bank is written in any clock;
- once the error flag is set, it stays set.

Other behaviour can only be shown by the bench's scenarios:
- which byte a write stores;
- that an aborted write changes no location;
- that the output stays off for a chip-enable-controlled cycle;
- the one-clock read latency.

The bench covers these with a full write and read sweep over every address and with targeted strobe orderings.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;
  typedef struct packed {
    logic ce;
    logic we;
    logic oe;
  } strobe_t;
endpackage

// File: rtl/sram_fe_dec.sv
module sram_fe_dec #(
  parameter int SEL_W = 2,
  localparam int N_OUT = 1 << SEL_W
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N_OUT-1:0] hot_o
);
  always_comb begin
    hot_o = '0;
    if (en_i) hot_o[sel_i] = 1'b1;
  end
endmodule

// File: rtl/sram_fe_bank.sv
module sram_fe_bank #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i) mem_q[widx_i] <= wdata_i;
      rdata_o <= mem_q[ridx_i];
    end
  end
endmodule

// File: rtl/sram_fe_wctl.sv
module sram_fe_wctl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_i,
  input  logic              prot_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] caddr_o,
  output logic [DATA_W-1:0] cdata_o,
  output logic              err_o
);
  logic win_q, abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= 1'b0;
      abort_q <= 1'b0;
      err_o   <= 1'b0;
      caddr_o <= '0;
      cdata_o <= '0;
    end else if (win_i && !win_q) begin
      win_q   <= 1'b1;
      abort_q <= 1'b0;
      caddr_o <= addr_i;
      cdata_o <= data_i;
    end else if (win_i) begin
      cdata_o <= data_i;
      if (addr_i != caddr_o) begin
        abort_q <= 1'b1;
        err_o   <= 1'b1;
      end
    end else begin
      win_q <= 1'b0;
    end
  end

  // commit on the closing clock only
  assign commit_o = win_q && !win_i && !abort_q && !prot_i;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8
  AST_NO_COMMIT_IN_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_i |-> !commit_o); // R5
endmodule

// File: rtl/sram_fe.sv
module sram_fe #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              protect_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              err_o
);
  import sram_fe_pkg::*;

  localparam int IDX_W   = ADDR_W - BANK_W;
  localparam int N_BANKS = 1 << BANK_W;

  strobe_t act;
  logic ce_prev_q, hold_q;
  logic commit;
  logic [ADDR_W-1:0] caddr;
  logic [DATA_W-1:0] cdata;
  logic [N_BANKS-1:0] bank_we;
  logic [DATA_W-1:0] bank_rd [N_BANKS];
  logic [BANK_W-1:0] rsel_q;

  // protect masks every strobe
  assign act.ce = !ce_ni && !protect_i;
  assign act.we = !we_ni && !protect_i;
  assign act.oe = !oe_ni && !protect_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_prev_q <= 1'b0;
      hold_q    <= 1'b0;
      rsel_q    <= '0;
    end else begin
      ce_prev_q <= act.ce;
      // chip-enable-controlled cycle keeps the driver off until deselect
      hold_q    <= act.ce && (hold_q || (act.we && !ce_prev_q));
      rsel_q    <= addr_i[ADDR_W-1 -: BANK_W];
    end
  end

  assign data_oe_o = act.ce && !act.we && act.oe && !hold_q;
  assign data_o    = bank_rd[rsel_q];

  sram_fe_wctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .win_i    (act.ce && act.we),
    .prot_i   (protect_i),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .commit_o (commit),
    .caddr_o  (caddr),
    .cdata_o  (cdata),
    .err_o    (err_o)
  );

  sram_fe_dec #(.SEL_W(BANK_W)) u_dec (
    .en_i  (commit),
    .sel_i (caddr[ADDR_W-1 -: BANK_W]),
    .hot_o (bank_we)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    sram_fe_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we[b]),
      .widx_i  (caddr[IDX_W-1:0]),
      .wdata_i (cdata),
      .ridx_i  (addr_i[IDX_W-1:0]),
      .rdata_o (bank_rd[b])
    );
  end

  AST_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we)); // R1
  AST_DESEL_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !data_oe_o); // R2
  AST_WE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> !data_oe_o); // R6
  AST_PROT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protect_i |-> (bank_we == '0)); // R9
  AST_PROT_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protect_i |-> !data_oe_o); // R9
endmodule

// File: tb/sram_fe_tb.sv
module sram_fe_tb;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NA = 1 << AW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1, protect_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic data_oe_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] model [NA];

  always #5 clk_i = ~clk_i;

  sram_fe #(.ADDR_W(AW), .DATA_W(DW), .BANK_W(2)) u_dut (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .protect_i,
    .addr_i, .data_i, .data_o, .data_oe_o, .err_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic idle();
    ce_ni = 1; we_ni = 1; oe_ni = 1;
  endtask

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 37 + 11) ^ (a >> 2));
  endfunction

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    ce_ni = 0; we_ni = 1; oe_ni = 1; addr_i = a; data_i = d; tick();
    we_ni = 0; tick(); tick();
    we_ni = 1; tick();
    idle(); tick();
    model[a] = d;
  endtask

  task automatic rd(string req, logic [AW-1:0] a);
    ce_ni = 0; we_ni = 1; oe_ni = 0; addr_i = a; tick(); #1;
    check(req, {31'b0, data_oe_o}, 1);
    check(req, data_o, model[a]);
    idle(); tick();
  endtask

  task automatic do_reset();
    idle(); protect_i = 0; rst_ni = 0; repeat (3) tick(); rst_ni = 1; tick();
    for (int i = 0; i < NA; i++) model[i] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10: reset state
    check("R10 oe", {31'b0, data_oe_o}, 0);
    check("R10 err", {31'b0, err_o}, 0);
    rd("R10 mem0", 0);
    rd("R10 memtop", AW'(NA - 1));

    // R1/R5: full sweep, every address written then read back
    for (int a = 0; a < NA; a++) wr(AW'(a), pat(a));
    for (int a = 0; a < NA; a++) rd("R1 sweep", AW'(a));

    // R1: same low index in each bank stays distinct
    for (int b = 0; b < 4; b++) wr(AW'((b << (AW - 2)) | 5), DW'(8'hA0 + b));
    for (int b = 0; b < 4; b++) rd("R1 bank alias", AW'((b << (AW - 2)) | 5));

    // R4: one-clock read latency
    ce_ni = 0; we_ni = 1; oe_ni = 0; addr_i = 8'h10; tick();
    addr_i = 8'h11; #1;
    check("R4 old data held", data_o, model[8'h10]);
    tick();
    check("R4 new data", data_o, model[8'h11]);
    check("R4 driven", {31'b0, data_oe_o}, 1);
    idle(); tick();

    // R5: last data sampled before close wins
    ce_ni = 0; addr_i = 8'h20; data_i = 8'h11; tick();
    we_ni = 0; tick();
    data_i = 8'h22; tick();
    data_i = 8'h33; we_ni = 1; tick();
    idle(); tick();
    model[8'h20] = 8'h22;
    rd("R5 last sample", 8'h20);

    // R2: deselected strobes do nothing
    ce_ni = 1; we_ni = 0; oe_ni = 0; addr_i = 8'h21; data_i = 8'h5A; #1;
    check("R2 no drive", {31'b0, data_oe_o}, 0);
    repeat (3) tick();
    we_ni = 1; tick();
    rd("R2 no write", 8'h21);

    // R3: selected, no write, no output
    ce_ni = 0; we_ni = 1; oe_ni = 1; addr_i = 8'h22; data_i = 8'hC3; #1;
    check("R3 no drive", {31'b0, data_oe_o}, 0);
    repeat (3) tick();
    idle(); tick();
    rd("R3 no write", 8'h22);

    // R6: we falling releases driver, then ce-first write re-drives
    ce_ni = 0; we_ni = 1; oe_ni = 0; addr_i = 8'h30; data_i = 8'h77; tick(); #1;
    check("R6 driven", {31'b0, data_oe_o}, 1);
    we_ni = 0; #1;
    check("R6 released", {31'b0, data_oe_o}, 0);
    tick(); tick();
    we_ni = 1; tick();
    model[8'h30] = 8'h77;
    check("R7 ce-first redrive", {31'b0, data_oe_o}, 1);
    tick();
    check("R6 write data", data_o, 8'h77);
    idle(); tick();

    // R7: ce falls after we, output stays off
    we_ni = 0; oe_ni = 0; addr_i = 8'h31; data_i = 8'h99; tick();
    ce_ni = 0; tick(); tick();
    we_ni = 1; tick();
    model[8'h31] = 8'h99;
    check("R7 held off", {31'b0, data_oe_o}, 0);
    tick();
    check("R7 still off", {31'b0, data_oe_o}, 0);
    ce_ni = 1; tick();
    ce_ni = 0; tick();
    check("R7 after reselect", {31'b0, data_oe_o}, 1);
    check("R7 data", data_o, 8'h99);
    idle(); tick();
    // R7: simultaneous fall
    ce_ni = 0; we_ni = 0; oe_ni = 0; addr_i = 8'h32; data_i = 8'h44; tick(); tick();
    we_ni = 1; tick();
    model[8'h32] = 8'h44;
    check("R7 simultaneous", {31'b0, data_oe_o}, 0);
    idle(); tick();
    rd("R7 simultaneous data", 8'h32);

    // R9: protect masks strobes
    protect_i = 1;
    ce_ni = 0; we_ni = 1; oe_ni = 0; addr_i = 8'h40; #1;
    check("R9 no drive", {31'b0, data_oe_o}, 0);
    data_i = 8'hEE; we_ni = 0; repeat (3) tick();
    we_ni = 1; tick(); idle(); tick();
    protect_i = 0; tick();
    rd("R9 no write", 8'h40);
    // R9: protect rises mid-window
    ce_ni = 0; addr_i = 8'h41; data_i = 8'hDD; we_ni = 0; tick(); tick();
    protect_i = 1; tick();
    idle(); tick();
    protect_i = 0; tick();
    rd("R9 cancelled", 8'h41);
    check("R9 err untouched", {31'b0, err_o}, 0);

    // R8: address change aborts, sticky error
    ce_ni = 0; addr_i = 8'h50; data_i = 8'hBB; we_ni = 0; tick();
    addr_i = 8'h51; tick(); tick();
    we_ni = 1; tick(); idle(); tick();
    check("R8 err set", {31'b0, err_o}, 1);
    rd("R8 first addr kept", 8'h50);
    rd("R8 second addr kept", 8'h51);
    wr(8'h52, 8'h12);
    rd("R8 later write", 8'h52);
    check("R8 err sticky", {31'b0, err_o}, 1);

    // R10: reset clears error and memory
    do_reset();
    check("R10 err cleared", {31'b0, err_o}, 0);
    rd("R10 mem cleared", 8'h52);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule